// File: doc/BRIEF.md
# Synchronous Dual-Port RAM with Selectable Read Latency

This block is a true dual-port RAM. It has two independent ports, A and B. Each port has its own clock, a word address, a 9-bit write-data input, a 9-bit read-data output, and a drive flag. The drive flag stands in for the enable of an external tri-state buffer. Either port may read or write any word in any cycle, including the word the other port is using. Address, data and control are all sampled on the rising edge of the port's clock.

Each port is selected only when two enables agree: an active-low enable `en_n_x` is low and an active-high enable `en_x` is high. These two enables allow memory depth to be extended without extra decode logic. A selected port writes when `wr_n_x` is low and reads when it is high. An output-enable `oe_n_x` gates the drive flag combinationally, without waiting for a clock. A strap `pipe_x` sets the read latency:
- 0 gives flow-through, where data is presented right after the sampling edge.
- 1 gives pipelined, where data is presented one clock later.

The depth is `2**ADDR_W` words. A value of 14 gives 16K words and 13 gives 8K words. The default is smaller so that elaboration stays light.

Top module: `dpram_sync`

## Requirements
- R1: A port is deselected when `en_n_x` is 1 or `en_x` is 0. A deselected port stores nothing, whatever `wr_n_x` and `din_x` are, and its drive flag is 0 for the cycle that follows.
- R2: When a port is selected and `wr_n_x` is 0 at a rising edge, `din_x` is stored at `addr_x`. The drive flag is 0 in the output slot of that access.
- R3: With `pipe_x`=0, a selected read with `wr_n_x`=1 at edge k presents the word at `addr_x` on `dout_x` with `drive_x`=1 from edge k until edge k+1.
- R4: With `pipe_x`=1, the same read presents its word from edge k+1 until edge k+2.
- R5: While `oe_n_x` is 1, `drive_x` is 0 immediately, with no clock edge needed. Returning `oe_n_x` to 0 restores the drive of the pending read.
- R6: Both ports may read the same word at the same edge, and both return it.
- R7: A word written by one port at edge k is returned by a read on the other port at edge k+1 or later.
- R8: When the two ports write the same word at different edges, the later write is what reads return. When they write it at the same edge, the content is undefined until it is written again.
- R9: In pipelined mode, `dout_x` keeps its last read value while the port is deselected or writing.
- R10: While `rst_n` is 0, both drive flags are 0.
- R11: A read at the same edge as a write by the other port to the same word returns the previous content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of the output stages |
| clk_a | input | 1 | Port A clock |
| en_n_a | input | 1 | Port A active-low enable |
| en_a | input | 1 | Port A active-high enable |
| wr_n_a | input | 1 | Port A 0 = write, 1 = read |
| addr_a | input | ADDR_W | Port A word address |
| din_a | input | DATA_W | Port A write data |
| oe_n_a | input | 1 | Port A asynchronous active-low output enable |
| pipe_a | input | 1 | Port A 0 = flow-through, 1 = pipelined |
| dout_a | output | DATA_W | Port A read data |
| drive_a | output | 1 | Port A read data is driven |
| clk_b | input | 1 | Port B clock |
| en_n_b | input | 1 | Port B active-low enable |
| en_b | input | 1 | Port B active-high enable |
| wr_n_b | input | 1 | Port B 0 = write, 1 = read |
| addr_b | input | ADDR_W | Port B word address |
| din_b | input | DATA_W | Port B write data |
| oe_n_b | input | 1 | Port B asynchronous active-low output enable |
| pipe_b | input | 1 | Port B 0 = flow-through, 1 = pipelined |
| dout_b | output | DATA_W | Port B read data |
| drive_b | output | 1 | Port B read data is driven |

## Verification
The bench builds the block with ADDR_W=5 and DATA_W=9. The 32-word array can then be filled and read back completely in a few hundred cycles, and a random mix of reads and writes on both ports hits the same word often. This exercises same-edge reads, cross-port writes and the undefined double write without long runs. Both ports share one clock, so the cross-port ordering of R7, R8 and R11 is exact. The latency strap and the output enable are toggled in the middle of traffic.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
    localparam int NUM_PORTS = 2;

    typedef enum logic {
        LAT_FLOW = 1'b0,
        LAT_PIPE = 1'b1
    } lat_mode_e;
endpackage

// File: rtl/dpr_bank.sv
module dpr_bank #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 9,
    parameter int NRD    = 2,
    parameter bit FLIP   = 1'b0
) (
    input  logic                         clk,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            waddr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic                         tag_src,
    input  logic [NRD-1:0][ADDR_W-1:0]   raddr,
    output logic [NRD-1:0][DATA_W-1:0]   rdata,
    output logic [NRD-1:0]               rtag
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] word_q [DEPTH];
    logic              tag_q  [DEPTH];

    // one writer per bank; the tag records who wrote last
    always_ff @(posedge clk) begin
        if (we) begin
            word_q[waddr] <= wdata;
            tag_q[waddr]  <= tag_src ^ FLIP;
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rdata[r] = word_q[raddr[r]];
        assign rtag[r]  = tag_q[raddr[r]];
    end
endmodule

// File: rtl/dpr_port.sv
module dpr_port #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n,
    input  logic              en,
    input  logic              wr_n,
    input  logic              oe_n,
    input  logic              pipe,
    input  logic [DATA_W-1:0] rd_word,
    output logic              wr_go,
    output logic [DATA_W-1:0] dout,
    output logic              drive
);
    import dpr_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] flow_data;
        logic              flow_vld;
        logic [DATA_W-1:0] pipe_data;
        logic              pipe_vld;
    } stage_t;

    stage_t st_d, st_q;
    logic   sel, rd_go;

    assign sel   = ~en_n & en;
    assign rd_go = sel & wr_n;
    assign wr_go = sel & ~wr_n;

    always_comb begin
        st_d          = st_q;
        st_d.flow_vld = rd_go;
        if (rd_go) st_d.flow_data = rd_word;
        st_d.pipe_vld = st_q.flow_vld;
        if (st_q.flow_vld) st_d.pipe_data = st_q.flow_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    lat_mode_e mode;
    assign mode  = lat_mode_e'(pipe);
    assign dout  = (mode == LAT_PIPE) ? st_q.pipe_data : st_q.flow_data;
    assign drive = ~oe_n & ((mode == LAT_PIPE) ? st_q.pipe_vld : st_q.flow_vld);
endmodule

// File: rtl/dpram_sync.sv
module dpram_sync #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 9
) (
    input  logic              rst_n,
    input  logic              clk_a,
    input  logic              en_n_a,
    input  logic              en_a,
    input  logic              wr_n_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [DATA_W-1:0] din_a,
    input  logic              oe_n_a,
    input  logic              pipe_a,
    output logic [DATA_W-1:0] dout_a,
    output logic              drive_a,
    input  logic              clk_b,
    input  logic              en_n_b,
    input  logic              en_b,
    input  logic              wr_n_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [DATA_W-1:0] din_b,
    input  logic              oe_n_b,
    input  logic              pipe_b,
    output logic [DATA_W-1:0] dout_b,
    output logic              drive_b
);
    import dpr_pkg::*;
    localparam int NP = NUM_PORTS;

    logic [NP-1:0]                     clk_v, en_n_v, en_v, wr_n_v, oe_n_v, pipe_v;
    logic [NP-1:0]                     wr_go, drive_v;
    logic [NP-1:0][ADDR_W-1:0]         addr_v;
    logic [NP-1:0][DATA_W-1:0]         din_v, dout_v, word_v;
    logic [NP-1:0][NP-1:0][DATA_W-1:0] bank_rd;   // [bank][port]
    logic [NP-1:0][NP-1:0]             bank_tag;  // [bank][port]

    assign clk_v  = {clk_b,  clk_a};
    assign en_n_v = {en_n_b, en_n_a};
    assign en_v   = {en_b,   en_a};
    assign wr_n_v = {wr_n_b, wr_n_a};
    assign oe_n_v = {oe_n_b, oe_n_a};
    assign pipe_v = {pipe_b, pipe_a};
    assign addr_v = {addr_b, addr_a};
    assign din_v  = {din_b,  din_a};

    for (genvar p = 0; p < NP; p++) begin : g_port
        // bank p copies the other bank's tag (flipped for bank 1)
        dpr_bank #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .NRD    (NP),
            .FLIP   (p != 0)
        ) u_bank (
            .clk     (clk_v[p]),
            .we      (wr_go[p]),
            .waddr   (addr_v[p]),
            .wdata   (din_v[p]),
            .tag_src (bank_tag[NP-1-p][p]),
            .raddr   (addr_v),
            .rdata   (bank_rd[p]),
            .rtag    (bank_tag[p])
        );

        // tags equal: bank 0 wrote last; tags differ: bank 1
        assign word_v[p] = (bank_tag[0][p] ^ bank_tag[1][p]) ? bank_rd[1][p] : bank_rd[0][p];

        dpr_port #(.DATA_W(DATA_W)) u_ctl (
            .clk     (clk_v[p]),
            .rst_n   (rst_n),
            .en_n    (en_n_v[p]),
            .en      (en_v[p]),
            .wr_n    (wr_n_v[p]),
            .oe_n    (oe_n_v[p]),
            .pipe    (pipe_v[p]),
            .rd_word (word_v[p]),
            .wr_go   (wr_go[p]),
            .dout    (dout_v[p]),
            .drive   (drive_v[p])
        );
    end

    assign dout_a  = dout_v[0];
    assign dout_b  = dout_v[1];
    assign drive_a = drive_v[0];
    assign drive_b = drive_v[1];
endmodule

// File: rtl/dpram_sync_chk.sv
module dpram_sync_chk #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 9
) (
    input logic              rst_n,
    input logic              clk_a,
    input logic              en_n_a,
    input logic              en_a,
    input logic              wr_n_a,
    input logic [ADDR_W-1:0] addr_a,
    input logic [DATA_W-1:0] din_a,
    input logic              oe_n_a,
    input logic              pipe_a,
    input logic [DATA_W-1:0] dout_a,
    input logic              drive_a,
    input logic              clk_b,
    input logic              en_n_b,
    input logic              en_b,
    input logic              wr_n_b,
    input logic [ADDR_W-1:0] addr_b,
    input logic [DATA_W-1:0] din_b,
    input logic              oe_n_b,
    input logic              pipe_b,
    input logic [DATA_W-1:0] dout_b,
    input logic              drive_b
);
    logic rd_a, rd_b, wr_a, wr_b;
    assign rd_a = ~en_n_a & en_a & wr_n_a;
    assign rd_b = ~en_n_b & en_b & wr_n_b;
    assign wr_a = ~en_n_a & en_a & ~wr_n_a;
    assign wr_b = ~en_n_b & en_b & ~wr_n_b;

    // R10: reset keeps both ports quiet
    always_comb begin
        if (!rst_n) begin
            a_r10_reset_quiet: assert (!drive_a && !drive_b);
        end
    end

    a_r5_oe_gate_a: assert property (@(posedge clk_a) disable iff (!rst_n)
        oe_n_a |-> !drive_a);
    a_r5_oe_gate_b: assert property (@(posedge clk_b) disable iff (!rst_n)
        oe_n_b |-> !drive_b);

    a_r3_flow_drive_a: assert property (@(posedge clk_a) disable iff (!rst_n)
        (!pipe_a && !oe_n_a) |-> (drive_a == $past(rd_a && rst_n)));
    a_r3_flow_drive_b: assert property (@(posedge clk_b) disable iff (!rst_n)
        (!pipe_b && !oe_n_b) |-> (drive_b == $past(rd_b && rst_n)));

    a_r4_pipe_drive_a: assert property (@(posedge clk_a) disable iff (!rst_n)
        (pipe_a && !oe_n_a) |-> (drive_a == $past(rd_a && rst_n, 2)));
    a_r4_pipe_drive_b: assert property (@(posedge clk_b) disable iff (!rst_n)
        (pipe_b && !oe_n_b) |-> (drive_b == $past(rd_b && rst_n, 2)));

    a_r2_write_quiet_a: assert property (@(posedge clk_a) disable iff (!rst_n)
        (!pipe_a && $past(wr_a)) |-> !drive_a);
    a_r1_desel_quiet_b: assert property (@(posedge clk_b) disable iff (!rst_n)
        (!pipe_b && $past(!rd_b && !wr_b)) |-> !drive_b);

    a_r9_pipe_hold_a: assert property (@(posedge clk_a) disable iff (!rst_n)
        (pipe_a && $past(pipe_a) && $past(rst_n) && !$past(rd_a && rst_n, 2))
        |-> $stable(dout_a));
    a_r9_pipe_hold_b: assert property (@(posedge clk_b) disable iff (!rst_n)
        (pipe_b && $past(pipe_b) && $past(rst_n) && !$past(rd_b && rst_n, 2))
        |-> $stable(dout_b));
endmodule

bind dpram_sync dpram_sync_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_dpram_sync.sv
module test_dpram_sync;
    localparam int AW    = 5;
    localparam int DW    = 9;
    localparam int WORDS = 1 << AW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [1:0]     en_n = 2'b11, en = 2'b11, wr_n = 2'b11, oe_n = 2'b00, pipe = 2'b00;
    logic [AW-1:0]  addr [2];
    logic [DW-1:0]  din  [2];
    logic [DW-1:0]  dout [2];
    logic [1:0]     drive;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    string phase = "R10";

    always #4 clk = ~clk;

    dpram_sync #(.ADDR_W(AW), .DATA_W(DW)) i_dpram_sync (
        .rst_n (rst_n),
        .clk_a (clk), .en_n_a (en_n[0]), .en_a (en[0]), .wr_n_a (wr_n[0]),
        .addr_a (addr[0]), .din_a (din[0]), .oe_n_a (oe_n[0]), .pipe_a (pipe[0]),
        .dout_a (dout[0]), .drive_a (drive[0]),
        .clk_b (clk), .en_n_b (en_n[1]), .en_b (en[1]), .wr_n_b (wr_n[1]),
        .addr_b (addr[1]), .din_b (din[1]), .oe_n_b (oe_n[1]), .pipe_b (pipe[1]),
        .dout_b (dout[1]), .drive_b (drive[1])
    );

    // behavioural reference model
    int unsigned mem_m   [WORDS];
    bit          known_m [WORDS];
    int unsigned fd [2], pd [2];
    bit          fv [2], pv [2], fk [2], pk [2];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < 2; p++) begin
                fd[p] = 0; pd[p] = 0; fv[p] = 0; pv[p] = 0; fk[p] = 1; pk[p] = 1;
            end
        end else begin
            bit wr [2];
            for (int p = 0; p < 2; p++) begin
                bit s;
                s = !en_n[p] && en[p];
                pv[p] = fv[p];
                if (fv[p]) begin pd[p] = fd[p]; pk[p] = fk[p]; end
                fv[p] = s && wr_n[p];
                if (fv[p]) begin fd[p] = mem_m[addr[p]]; fk[p] = known_m[addr[p]]; end
                wr[p] = s && !wr_n[p];
            end
            for (int p = 0; p < 2; p++)
                if (wr[p]) begin mem_m[addr[p]] = din[p]; known_m[addr[p]] = 1; end
            if (wr[0] && wr[1] && addr[0] == addr[1]) known_m[addr[0]] = 0;
        end
    end

    task automatic chk(bit ok, string tag, int got, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int p = 0; p < 2; p++) begin
                bit ed, ek;
                int unsigned ev;
                ed = !oe_n[p] && (pipe[p] ? pv[p] : fv[p]);
                ek = pipe[p] ? pk[p] : fk[p];
                ev = pipe[p] ? pd[p] : fd[p];
                chk(drive[p] == ed, $sformatf("%s drive port%0d (R3 flow/R4 pipe)", phase, p),
                    int'(drive[p]), int'(ed));
                if (ed && ek)
                    chk(dout[p] == DW'(ev), $sformatf("%s data port%0d", phase, p),
                        int'(dout[p]), int'(ev));
            end
        end
    end

    function automatic logic [DW-1:0] pat(int i);
        return DW'(i * 37 + 5);
    endfunction

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic op(int p, bit s, bit w, int a, int d);
        en_n[p] = !s; en[p] = 1'b1; wr_n[p] = !w;
        addr[p] = AW'(a); din[p] = DW'(d);
    endtask

    task automatic idle(int p);
        en_n[p] = 1'b1; en[p] = 1'b1; wr_n[p] = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < WORDS; i++) begin mem_m[i] = 0; known_m[i] = 0; end
        addr[0] = '0; addr[1] = '0; din[0] = '0; din[1] = '0;
        // R10 reset: drive low even with a read requested
        repeat (3) @(posedge clk);
        en_n = 2'b00; wr_n = 2'b11;
        @(negedge clk);
        chk(drive == 2'b00, "R10 reset drive", int'(drive), 0);
        idle(0); idle(1);
        @(posedge clk); #2;
        rst_n = 1'b1;
        tick();

        // R2: port A fills the array
        phase = "R2";
        for (int i = 0; i < WORDS; i++) begin op(0, 1, 1, i, pat(i)); tick(); end
        idle(0);

        // R3: port B reads everything flow-through
        phase = "R3";
        for (int i = 0; i < WORDS; i++) begin
            op(1, 1, 0, i, 0); tick();
            chk(drive[1] && dout[1] == pat(i), "R3 flow read", int'(dout[1]), int'(pat(i)));
        end
        idle(1); tick();

        // R4: port A reads pipelined
        phase = "R4";
        pipe[0] = 1'b1; tick(); tick();
        op(0, 1, 0, 11, 0); tick(); idle(0);
        chk(drive[0] == 1'b0, "R4 not yet driven", int'(drive[0]), 0);
        tick();
        chk(drive[0] && dout[0] == pat(11), "R4 pipe read", int'(dout[0]), int'(pat(11)));
        for (int i = 0; i < WORDS; i++) begin op(0, 1, 0, WORDS - 1 - i, 0); tick(); end
        idle(0); tick(); tick();
        pipe[0] = 1'b0; tick();

        // R5: output enable acts without a clock
        phase = "R5";
        op(0, 1, 0, 2, 0); tick(); idle(0);
        oe_n[0] = 1'b1; #1;
        chk(drive[0] == 1'b0, "R5 oe off", int'(drive[0]), 0);
        oe_n[0] = 1'b0; #1;
        chk(drive[0] == 1'b1 && dout[0] == pat(2), "R5 oe on", int'(dout[0]), int'(pat(2)));
        tick();

        // R6: same word read by both ports at once
        phase = "R6";
        op(0, 1, 0, 4, 0); op(1, 1, 0, 4, 0); tick();
        chk(dout[0] == pat(4) && dout[1] == pat(4), "R6 both read", int'(dout[1]), int'(pat(4)));
        idle(0); idle(1); tick();

        // R7: write on A, read on B next edge
        phase = "R7";
        op(0, 1, 1, 5, 9'h0F0); tick(); idle(0);
        op(1, 1, 0, 5, 0); tick(); idle(1);
        chk(dout[1] == 9'h0F0, "R7 cross visibility", int'(dout[1]), 9'h0F0);

        // R11: read on A while B writes the same word
        phase = "R11";
        op(0, 1, 0, 5, 0); op(1, 1, 1, 5, 9'h033); tick(); idle(0); idle(1);
        chk(dout[0] == 9'h0F0, "R11 old value", int'(dout[0]), 9'h0F0);
        tick();

        // R8: later writer wins; same-edge double write then rewrite
        phase = "R8";
        op(0, 1, 1, 7, 9'h0AA); tick(); idle(0);
        op(1, 1, 1, 7, 9'h155); tick(); idle(1);
        op(0, 1, 0, 7, 0); tick(); idle(0);
        chk(dout[0] == 9'h155, "R8 last writer", int'(dout[0]), 9'h155);
        op(0, 1, 1, 3, 9'h1C1); op(1, 1, 1, 3, 9'h03E); tick(); idle(1);
        op(0, 1, 1, 3, 9'h011); tick(); idle(0);
        op(1, 1, 0, 3, 0); tick(); idle(1);
        chk(dout[1] == 9'h011, "R8 rewrite after collision", int'(dout[1]), 9'h011);

        // R1: deselected writes, both enable polarities
        phase = "R1";
        en_n[0] = 1'b1; en[0] = 1'b1; wr_n[0] = 1'b0; addr[0] = 8; din[0] = 9'h1FF; tick();
        en_n[0] = 1'b0; en[0] = 1'b0; wr_n[0] = 1'b0; addr[0] = 9; din[0] = 9'h1FE; tick();
        idle(0);
        chk(drive[0] == 1'b0, "R1 deselect quiet", int'(drive[0]), 0);
        op(1, 1, 0, 8, 0); tick();
        chk(dout[1] == pat(8), "R1 word 8 kept", int'(dout[1]), int'(pat(8)));
        op(1, 1, 0, 9, 0); tick(); idle(1);
        chk(dout[1] == pat(9), "R1 word 9 kept", int'(dout[1]), int'(pat(9)));

        // R9: pipelined data holds while deselected and writing
        phase = "R9";
        pipe[1] = 1'b1; tick(); tick();
        op(1, 1, 0, 10, 0); tick(); idle(1); tick(); tick();
        op(1, 1, 1, 12, 9'h0C3); tick(); idle(1); tick();
        chk(drive[1] == 1'b0 && dout[1] == pat(10), "R9 pipe hold", int'(dout[1]), int'(pat(10)));
        pipe[1] = 1'b0; tick();

        // mixed random traffic (R6, R7, R8, R11 coverage)
        phase = "R7 random";
        for (int c = 0; c < 3000; c++) begin
            for (int p = 0; p < 2; p++) begin
                int k;
                k = $urandom_range(0, 7);
                if (k == 0)      begin op(p, 0, $urandom_range(0, 1), $urandom_range(0, WORDS - 1), $urandom); end
                else if (k == 1) begin op(p, 1, 1, $urandom_range(0, WORDS - 1), $urandom); en[p] = 1'b0; end
                else if (k < 4)  op(p, 1, 1, $urandom_range(0, WORDS - 1), $urandom);
                else             op(p, 1, 0, $urandom_range(0, WORDS - 1), 0);
                if ($urandom_range(0, 63) == 0) pipe[p] = ~pipe[p];
                oe_n[p] = ($urandom_range(0, 7) == 0);
            end
            tick();
        end
        idle(0); idle(1); oe_n = 2'b00;
        tick(); tick();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule